// File: doc/BRIEF.md
# Compass heading decoder with settling

This block sits between a slow magnetic compass module and the logic that steers by it. The module has four open-drain direction lines that are pulled high and go low when active: north, east, south and west. One low line names a cardinal heading. Two neighbouring lines low at the same time name the diagonal between them. The block brings the lines into the clock domain, decodes them into a 3-bit heading code and drives a valid flag and a one-cycle pulse for each change of heading.

The sensor swings slowly and passes through intermediate patterns while it moves. For that reason a newly decoded value reaches the outputs only after it has been seen on `SETTLE_CYCLES` clock edges in a row. Any change in the decoded value starts that count again. A pattern that no real heading produces (no line low, two opposite lines low, or three or more lines low) clears the valid flag once it has settled. The heading output keeps the last good value.

Top module: `compass_heading_decoder`

## Requirements
- R1: Line bits are dir_n_i[0]=north, [1]=east, [2]=south, [3]=west, active low. A single low line settles to heading code north=0, east=2, south=4, west=6, with valid_o high.
- R2: Two adjacent low lines settle to a diagonal code: north+east=1, east+south=3, south+west=5, west+north=7, with valid_o high.
- R3: All lines high, north+south low, east+west low, or three or more lines low is an invalid pattern. Once settled it drives valid_o low and leaves heading_o at its previous value, with no pulse on changed_o.
- R4: The lines pass through a two-flop synchronizer. An input change held steady reaches the outputs on exactly the (SETTLE_CYCLES+2)-th rising edge after it is applied, and not before.
- R5: The outputs take a decoded value only after it has been sampled on SETTLE_CYCLES consecutive edges. A different value seen on any edge restarts the count, so a pattern held for SETTLE_CYCLES-1 edges never reaches the outputs.
- R6: changed_o pulses high for exactly one cycle when a settled valid heading differs from heading_o, or when it arrives while valid_o is low. changed_o is never high while valid_o is low.
- R7: While rst_ni is low, and until a heading settles, heading_o=0, valid_o=0 and changed_o=0.
- R8: Reapplying the pattern already shown on the outputs changes nothing and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_n_i | input | 4 | Direction lines, active low: [0] north, [1] east, [2] south, [3] west |
| heading_o | output | 3 | Settled heading code, 0 to 7 clockwise from north |
| valid_o | output | 1 | Settled pattern is a real heading |
| changed_o | output | 1 | One-cycle pulse on each accepted heading change |

## Verification
The bench times the hold-off edge by edge. A design with one synchronizer stage too few, or with an off-by-one in the settle counter, updates one edge early or late and is caught. A pattern held for one edge fewer than the window, followed by a different heading, checks the restart: a counter that is never cleared would let the brief pattern through. A sweep of illegal patterns and a return to the same heading check that the heading is held while valid is low and that the regain pulse appears. A decoder that maps opposite lines to a heading, or that clears the heading on an invalid pattern, fails these checks. Random patterns with short and long holds then check that short holds never reach the outputs and that long holds always do.

// File: rtl/compass_pkg.sv
`timescale 1ns/1ps
package compass_pkg;
  typedef logic [2:0] heading_t;

  localparam heading_t HD_N  = 3'd0;
  localparam heading_t HD_NE = 3'd1;
  localparam heading_t HD_E  = 3'd2;
  localparam heading_t HD_SE = 3'd3;
  localparam heading_t HD_S  = 3'd4;
  localparam heading_t HD_SW = 3'd5;
  localparam heading_t HD_W  = 3'd6;
  localparam heading_t HD_NW = 3'd7;

  // hd is forced to zero when legal is low, so every invalid pattern compares equal
  typedef struct packed {
    logic     legal;
    heading_t hd;
  } dec_t;
endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
  parameter int unsigned    WIDTH  = 4,
  parameter int unsigned    STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_decode.sv
`timescale 1ns/1ps
module cmp_decode
  import compass_pkg::*;
(
  input  logic [3:0] lines_n_i,
  output dec_t       dec_o
);
  logic [3:0] low;
  assign low = ~lines_n_i;

  always_comb begin
    dec_o = '0;
    unique case (low)
      4'b0001: dec_o = '{legal: 1'b1, hd: HD_N};
      4'b0011: dec_o = '{legal: 1'b1, hd: HD_NE};
      4'b0010: dec_o = '{legal: 1'b1, hd: HD_E};
      4'b0110: dec_o = '{legal: 1'b1, hd: HD_SE};
      4'b0100: dec_o = '{legal: 1'b1, hd: HD_S};
      4'b1100: dec_o = '{legal: 1'b1, hd: HD_SW};
      4'b1000: dec_o = '{legal: 1'b1, hd: HD_W};
      4'b1001: dec_o = '{legal: 1'b1, hd: HD_NW};
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_settle.sv
`timescale 1ns/1ps
module cmp_settle
  import compass_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 500_000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dec_t     dec_i,
  output heading_t heading_o,
  output logic     valid_o,
  output logic     changed_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  dec_t             cand_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             diff, accept;

  assign diff    = (dec_i != cand_q);
  // saturating run length of the current decoded value
  assign cnt_nxt = diff ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1));
  assign accept  = (cnt_nxt == CNT_MAX) && (diff || (cnt_q != CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else begin
      cand_q <= dec_i;
      cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      heading_o <= HD_N;
      valid_o   <= 1'b0;
      changed_o <= 1'b0;
    end else begin
      changed_o <= 1'b0;
      if (accept) begin
        valid_o <= dec_i.legal;
        if (dec_i.legal) begin
          heading_o <= dec_i.hd;
          changed_o <= !valid_o || (dec_i.hd != heading_o);
        end
      end
    end
  end

  a_r6_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> valid_o);

  a_r3_heading_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $stable(heading_o));

  a_r5_update_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(heading_o) || !$stable(valid_o)) |-> (cnt_q == CNT_MAX));

  a_r6_pulse_reason: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> (!$stable(heading_o) || $rose(valid_o)));
endmodule

// File: rtl/compass_heading_decoder.sv
`timescale 1ns/1ps
module compass_heading_decoder
  import compass_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 500_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] dir_n_i,
  output logic [2:0] heading_o,
  output logic       valid_o,
  output logic       changed_o
);
  logic [3:0] sync_n;
  dec_t       dec;

  cmp_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'hF)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dir_n_i),
    .q_o   (sync_n)
  );

  cmp_decode i_decode (
    .lines_n_i(sync_n),
    .dec_o    (dec)
  );

  cmp_settle #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec),
    .heading_o(heading_o),
    .valid_o  (valid_o),
    .changed_o(changed_o)
  );

  a_r2_legal_line_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.legal |-> ($countones(~sync_n) == 1 || $countones(~sync_n) == 2));

  a_r1_single_low_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~sync_n) == 1) |-> dec.legal);

  a_r3_opposite_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!sync_n[0] && !sync_n[2]) || (!sync_n[1] && !sync_n[3])) |-> !dec.legal);
endmodule

// File: tb/test_compass_heading_decoder.sv
`timescale 1ns/1ps
module test_compass_heading_decoder;
  localparam int unsigned SETTLE = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] dir_n = 4'hF;
  logic [2:0] heading_o;
  logic       valid_o, changed_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] model_hd = 3'd0;
  logic       model_valid = 1'b0;

  always #2.5 clk = ~clk;

  compass_heading_decoder #(.SETTLE_CYCLES(SETTLE)) i_compass_heading_decoder (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .dir_n_i  (dir_n),
    .heading_o(heading_o),
    .valid_o  (valid_o),
    .changed_o(changed_o)
  );

  // expected decode from line counting: heading = 2*i for line i, 2*i+1 for lines i and i+1
  function automatic logic [3:0] ref_dec(input logic [3:0] pat);
    logic [3:0] low;
    int n;
    low = ~pat;
    n = $countones(low);
    if (n == 1) begin
      for (int i = 0; i < 4; i++) if (low[i]) return {1'b1, 3'(2 * i)};
    end else if (n == 2) begin
      for (int i = 0; i < 4; i++) if (low[i] && low[(i + 1) % 4]) return {1'b1, 3'(2 * i + 1)};
    end
    return 4'b0000;
  endfunction

  function automatic logic [3:0] pat_of(input logic [2:0] h);
    logic [3:0] low;
    int i;
    i = h / 2;
    low = 4'b0001 << i;
    if (h[0]) low = low | (4'b0001 << ((i + 1) % 4));
    return ~low;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_check(input logic [3:0] pat, input string req);
    logic [2:0] ohd, ehd;
    logic       ov, ev, ep;
    logic [3:0] d;
    d   = ref_dec(pat);
    ev  = d[3];
    ehd = d[3] ? d[2:0] : model_hd;
    ep  = d[3] && (!model_valid || d[2:0] != model_hd);
    @(negedge clk);
    ohd = heading_o;
    ov  = valid_o;
    dir_n = pat;
    repeat (SETTLE + 1) @(posedge clk);
    #1;
    chk(req, "heading before window", heading_o, ohd);
    chk(req, "valid before window", valid_o, ov);
    chk(req, "pulse before window", changed_o, 1'b0);
    @(posedge clk);
    #1;
    chk(req, "heading", heading_o, ehd);
    chk(req, "valid", valid_o, ev);
    chk(req, "pulse", changed_o, ep);
    @(posedge clk);
    #1;
    chk(req, "pulse width", changed_o, 1'b0);
    model_hd = ehd;
    model_valid = ev;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired: actual running expected finished");
    summary();
  end

  initial begin
    logic [3:0] prev, pat, d;
    int len;
    bit long_hold;
    void'($urandom(32'd20250611));

    repeat (4) @(posedge clk);
    #1;
    chk("R7", "heading in reset", heading_o, 3'd0);
    chk("R7", "valid in reset", valid_o, 1'b0);
    chk("R7", "pulse in reset", changed_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (SETTLE + 4) @(posedge clk);
    #1;
    chk("R7", "heading idle", heading_o, 3'd0);
    chk("R7", "valid idle", valid_o, 1'b0);

    // R1 cardinals, R4 exact latency inside drive_check
    drive_check(4'b1110, "R1");
    drive_check(4'b1101, "R1");
    drive_check(4'b1011, "R1");
    drive_check(4'b0111, "R4");
    // R2 diagonals
    drive_check(4'b1100, "R2");
    drive_check(4'b1001, "R2");
    drive_check(4'b0011, "R2");
    drive_check(4'b0110, "R2");
    // R8 same pattern again
    drive_check(4'b0110, "R8");

    // R5 a heading held one edge short of the window, then another heading
    @(negedge clk);
    dir_n = 4'b1110;
    repeat (SETTLE - 1) @(posedge clk);
    drive_check(4'b0011, "R5");

    // R3 invalid patterns
    drive_check(4'b1111, "R3");
    drive_check(4'b1010, "R3");
    drive_check(4'b0101, "R3");
    drive_check(4'b1000, "R3");
    drive_check(4'b0000, "R3");
    // R6 regaining a valid heading pulses even when the code is unchanged
    drive_check(4'b0011, "R6");
    // R5 short invalid glitch does not drop valid
    @(negedge clk);
    dir_n = 4'b1111;
    repeat (SETTLE - 1) @(posedge clk);
    drive_check(4'b0011, "R5");

    // random holds: short holds never land, long holds always do
    prev = dir_n;
    for (int s = 0; s < 400; s++) begin
      do begin
        if ($urandom % 2) pat = pat_of(3'($urandom % 8));
        else              pat = 4'($urandom);
      end while (pat == prev);
      long_hold = ($urandom % 5) < 2;
      len = long_hold ? SETTLE + 3 + ($urandom % 8) : 1 + ($urandom % (SETTLE - 1));
      @(negedge clk);
      dir_n = pat;
      repeat (len) @(posedge clk);
      if (long_hold) begin
        #1;
        d = ref_dec(pat);
        if (d[3]) model_hd = d[2:0];
        model_valid = d[3];
        chk(d[3] ? "R2" : "R3", "random valid", valid_o, model_valid);
        chk(d[3] ? "R1" : "R3", "random heading", heading_o, model_hd);
      end
      prev = pat;
    end

    summary();
  end
endmodule